// File: doc/BRIEF.md
# Two-Level Bound Table Walker

This block finds the bound table entry that belongs to a pointer and then reads or writes that entry. The key is the address where the pointer itself is stored. The walk uses two structures in memory: a directory of 8-byte entries and bound tables of 32-byte entries. The directory entry supplies the base address of a table. The table entry holds four 64-bit words: lower bound, upper bound, pointer value and a reserved word.

A request is a one-cycle `start` while the block is idle. It carries the storage address, the privilege level, the user address-width adjust, the operation, and, for a store, the bounds and pointer value. The block first reads the directory entry. If bit 0 of that entry is clear, the walk ends with a fault and the table is not touched. Otherwise the block transfers the four table words over a 64-bit request/acknowledge memory port. A load returns the bounds, but forces them to the unbounded pair when the stored pointer value differs from the one supplied with the request. Both directory bases must stay stable while a walk is running.

Top module: `bt_walker`

## Requirements
- R1: When `priv` is below 3, the walk uses `base_sup` as the directory base and an adjust of 0. When `priv` equals 3, it uses `base_user` and `user_adj`. Adjust values above 16 are treated as 16.
- R2: The first memory access is a read (`mem_we`=0) at the directory base plus eight times the directory index. The index is formed from bits [47+adjust:20] of `ptr_addr`.
- R3: The first table access goes to the directory entry with its low 3 bits cleared, plus 32 times `ptr_addr[19:3]`.
- R4: If bit 0 of the fetched directory entry is 0, the block issues no further memory access. It then raises `done` and `fault` together for one cycle.
- R5: A store writes four words at the table entry address plus 0, 8, 16 and 24, in that order: `st_lb`, `st_ub`, `ptr_val`, then zero.
- R6: A load reads the four words at ascending addresses, with `mem_we`=0. It presents word 0 on `ld_lb`, word 1 on `ld_ub` and word 2 on `ld_ptr`, valid while `done` is high.
- R7: On a load whose fetched word 2 differs from `ptr_val`, `ld_lb` and `ld_ub` are both zero and `ld_ptr` still shows the fetched word.
- R8: A memory request holds its address, write enable and write data until `mem_ack`. Each acknowledge completes exactly one access, so a successful walk makes exactly five accesses.
- R9: `busy` is high from the cycle after an accepted `start` until the walk ends. `done` is a single-cycle pulse in the cycle after the last acknowledge, with `busy` already low.
- R10: After reset, `busy`, `done`, `fault` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| op_store | input | 1 | 1 = write the entry, 0 = read it |
| priv | input | 2 | Privilege level of the access |
| user_adj | input | 5 | User address-width adjust |
| ptr_addr | input | 64 | Address where the pointer is stored |
| ptr_val | input | 64 | Pointer value (written on store, compared on load) |
| st_lb | input | 64 | Lower bound to store |
| st_ub | input | 64 | Upper bound to store |
| base_user | input | 64 | Directory base for privilege 3 |
| base_sup | input | 64 | Directory base for privilege below 3 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Directory entry invalid (with done) |
| ld_lb | output | 64 | Loaded lower bound |
| ld_ub | output | 64 | Loaded upper bound |
| ld_ptr | output | 64 | Loaded pointer value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge (completes one access) |
| mem_rdata | input | 64 | Memory read data, valid with mem_ack |

## Verification
The properties inside the sequencer watch some rules on every cycle:
- a pending request holds its address and data;
- the table addresses step up by 8 between acknowledges;
- `done` never lasts two cycles;
- `fault` appears only with `done`, straight after the directory phase.

The address arithmetic can only be shown by the bench's scenarios against a logging memory model. That covers the privilege-dependent base and adjust selection, the adjust cap, masking of the metadata bits, the stored word contents, the mismatch rule and the absence of table traffic after an invalid entry.

// File: rtl/bt_pkg.sv
package bt_pkg;

    parameter int unsigned AW         = 64;
    parameter int unsigned BASE_BITS  = 48;
    parameter int unsigned DIR_LSB    = 20;
    parameter int unsigned TBL_LSB    = 3;
    parameter int unsigned DIR_ENT_SH = 3;
    parameter int unsigned TBL_ENT_SH = 5;
    parameter int unsigned WORDS      = 4;
    parameter int unsigned ADJ_W      = 5;
    parameter int unsigned META_BITS  = 3;
    parameter int unsigned VALID_BIT  = 0;

    localparam int unsigned BEAT_W    = $clog2(WORDS);
    localparam int unsigned KEEP      = WORDS - 1;
    localparam int unsigned WORD_B    = AW / 8;
    localparam int unsigned MAX_ADJ   = AW - BASE_BITS;
    localparam logic [1:0]  USER_PRIV = 2'd3;

    // positions of the words inside one table entry
    localparam int unsigned IDX_LB  = 0;
    localparam int unsigned IDX_UB  = 1;
    localparam int unsigned IDX_PTR = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL
    } walk_state_t;

    typedef struct packed {
        logic              store;
        logic [1:0]        priv;
        logic [ADJ_W-1:0]  adj;
        logic [AW-1:0]     ptr_addr;
        logic [AW-1:0]     ptr_val;
        logic [AW-1:0]     lb;
        logic [AW-1:0]     ub;
    } walk_req_t;

    function automatic logic [ADJ_W-1:0] eff_adj(input logic [1:0] priv,
                                                 input logic [ADJ_W-1:0] adj);
        if (priv != USER_PRIV)
            return '0;
        else if (adj > ADJ_W'(MAX_ADJ))
            return ADJ_W'(MAX_ADJ);
        else
            return adj;
    endfunction

    function automatic logic [AW-1:0] dir_offset(input logic [AW-1:0] a,
                                                 input logic [ADJ_W-1:0] adj);
        logic [AW-1:0] m;
        int unsigned   w;
        w = BASE_BITS + int'(adj);
        if (w >= AW)
            m = '1;
        else
            m = (AW'(1) << w) - AW'(1);
        return ((a & m) >> DIR_LSB) << DIR_ENT_SH;
    endfunction

    function automatic logic [AW-1:0] tbl_offset(input logic [AW-1:0] a);
        return AW'(a[DIR_LSB-1:TBL_LSB]) << TBL_ENT_SH;
    endfunction

endpackage

// File: rtl/bt_index_calc.sv
module bt_index_calc
    import bt_pkg::*;
(
    input  walk_req_t     req,
    input  logic [AW-1:0] base_user,
    input  logic [AW-1:0] base_sup,
    input  logic [AW-1:0] dir_entry,
    output logic [AW-1:0] dir_addr,
    output logic [AW-1:0] tbl_addr
);
    localparam logic [AW-1:0] META_MASK = AW'((1 << META_BITS) - 1);

    logic [ADJ_W-1:0] adj_eff;
    logic [AW-1:0]    dir_base;
    logic [AW-1:0]    tbl_base;

    always_comb begin
        adj_eff  = eff_adj(req.priv, req.adj);
        dir_base = (req.priv == USER_PRIV) ? base_user : base_sup;
        dir_addr = dir_base + dir_offset(req.ptr_addr, adj_eff);
        tbl_base = dir_entry & ~META_MASK;
        tbl_addr = tbl_base + tbl_offset(req.ptr_addr);
    end

endmodule

// File: rtl/bt_entry_buf.sv
module bt_entry_buf
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [BEAT_W-1:0] beat,
    input  logic [AW-1:0]     rdata,
    input  logic [AW-1:0]     ptr_cmp,
    input  logic              finish,
    output logic [AW-1:0]     lb_o,
    output logic [AW-1:0]     ub_o,
    output logic [AW-1:0]     ptr_o
);
    logic [AW-1:0] word_q [KEEP];

    // the reserved word is read but never kept
    for (genvar g = 0; g < KEEP; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[g] <= '0;
            else if (cap_en && beat == BEAT_W'(g))
                word_q[g] <= rdata;
        end
    end

    logic match;
    assign match = (word_q[IDX_PTR] == ptr_cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_o  <= '0;
            ub_o  <= '0;
            ptr_o <= '0;
        end else if (finish) begin
            lb_o  <= match ? word_q[IDX_LB] : '0;
            ub_o  <= match ? word_q[IDX_UB] : '0;
            ptr_o <= word_q[IDX_PTR];
        end
    end

endmodule

// File: rtl/bt_walk_seq.sv
module bt_walk_seq
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  walk_req_t         req_in,
    input  logic [AW-1:0]     dir_addr,
    input  logic [AW-1:0]     tbl_addr,
    input  logic              mem_ack,
    input  logic [AW-1:0]     mem_rdata,
    output walk_req_t         req_q,
    output logic [AW-1:0]     dir_entry_q,
    output logic [BEAT_W-1:0] beat,
    output logic              cap_en,
    output logic              finish_load,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_wdata
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);

    walk_state_t state;
    logic        last_ack;

    assign last_ack = (state == ST_TBL) && mem_ack && (beat == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            beat        <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            req_q       <= '0;
            dir_entry_q <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        beat  <= '0;
                        state <= ST_DIR;
                    end
                end
                ST_DIR: begin
                    if (mem_ack) begin
                        dir_entry_q <= mem_rdata;
                        if (!mem_rdata[VALID_BIT]) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            fault <= 1'b1;
                        end else begin
                            state <= ST_TBL;
                        end
                    end
                end
                ST_TBL: begin
                    if (mem_ack) begin
                        if (beat == LAST_BEAT) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            beat  <= '0;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        mem_req     = busy;
        mem_we      = (state == ST_TBL) && req_q.store;
        cap_en      = (state == ST_TBL) && mem_ack && !req_q.store;
        finish_load = last_ack && !req_q.store;
        if (state == ST_TBL)
            mem_addr = tbl_addr + (AW'(beat) * AW'(WORD_B));
        else
            mem_addr = dir_addr;
        unique case (beat)
            BEAT_W'(IDX_LB):  mem_wdata = req_q.lb;
            BEAT_W'(IDX_UB):  mem_wdata = req_q.ub;
            BEAT_W'(IDX_PTR): mem_wdata = req_q.ptr_val;
            default:          mem_wdata = '0;
        endcase
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R5
    tbl_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_TBL) && mem_ack && beat != LAST_BEAT)
            |=> (mem_addr == $past(mem_addr) + AW'(WORD_B)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    fault_done_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (done && !busy));

    // R4
    fault_src_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(state == ST_DIR));

endmodule

// File: rtl/bt_walker.sv
module bt_walker
    import bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_store,
    input  logic [1:0]       priv,
    input  logic [ADJ_W-1:0] user_adj,
    input  logic [AW-1:0]    ptr_addr,
    input  logic [AW-1:0]    ptr_val,
    input  logic [AW-1:0]    st_lb,
    input  logic [AW-1:0]    st_ub,
    input  logic [AW-1:0]    base_user,
    input  logic [AW-1:0]    base_sup,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [AW-1:0]    ld_lb,
    output logic [AW-1:0]    ld_ub,
    output logic [AW-1:0]    ld_ptr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_rdata
);
    walk_req_t         req_in;
    walk_req_t         req_q;
    logic [AW-1:0]     dir_entry_q;
    logic [AW-1:0]     dir_addr;
    logic [AW-1:0]     tbl_addr;
    logic [BEAT_W-1:0] beat;
    logic              cap_en;
    logic              finish_load;

    always_comb begin
        req_in.store    = op_store;
        req_in.priv     = priv;
        req_in.adj      = user_adj;
        req_in.ptr_addr = ptr_addr;
        req_in.ptr_val  = ptr_val;
        req_in.lb       = st_lb;
        req_in.ub       = st_ub;
    end

    bt_index_calc u_calc (
        .req       (req_q),
        .base_user (base_user),
        .base_sup  (base_sup),
        .dir_entry (dir_entry_q),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr)
    );

    bt_walk_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req_in      (req_in),
        .dir_addr    (dir_addr),
        .tbl_addr    (tbl_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .req_q       (req_q),
        .dir_entry_q (dir_entry_q),
        .beat        (beat),
        .cap_en      (cap_en),
        .finish_load (finish_load),
        .busy        (busy),
        .done        (done),
        .fault       (fault),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    bt_entry_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .beat    (beat),
        .rdata   (mem_rdata),
        .ptr_cmp (req_q.ptr_val),
        .finish  (finish_load),
        .lb_o    (ld_lb),
        .ub_o    (ld_ub),
        .ptr_o   (ld_ptr)
    );

endmodule

// File: tb/tb_bt_walker.sv
module tb_bt_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_store = 1'b0;
    logic [1:0]  priv = '0;
    logic [4:0]  user_adj = '0;
    logic [63:0] ptr_addr = '0, ptr_val = '0, st_lb = '0, st_ub = '0;
    logic [63:0] base_user = '0, base_sup = '0;
    logic        busy, done, fault, mem_req, mem_we;
    logic [63:0] ld_lb, ld_ub, ld_ptr, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #2 clk = ~clk;

    bt_walker dut (
        .clk(clk), .rst(rst), .start(start), .op_store(op_store), .priv(priv),
        .user_adj(user_adj), .ptr_addr(ptr_addr), .ptr_val(ptr_val),
        .st_lb(st_lb), .st_ub(st_ub), .base_user(base_user), .base_sup(base_sup),
        .busy(busy), .done(done), .fault(fault), .ld_lb(ld_lb), .ld_ub(ld_ub),
        .ld_ptr(ld_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] log_addr [$];
    bit          log_we [$];
    int          wait_cnt = 0;

    // memory model: answers at the falling edge, one access per acknowledge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                log_addr.push_back(mem_addr);
                log_we.push_back(mem_we);
                if (mem_we)
                    mem[mem_addr] = mem_wdata;
                else
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
                mem_ack = 1'b1;
                wait_cnt = $urandom_range(0, 2);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_dir(input logic [63:0] p, input logic [1:0] pl,
                                            input logic [4:0] a, input logic [63:0] ub,
                                            input logic [63:0] sb);
        int          ea;
        logic [63:0] idx;
        ea = (pl == 2'd3) ? ((a > 5'd16) ? 16 : int'(a)) : 0;
        idx = p >> 20;
        if (28 + ea < 64)
            idx = idx & ((64'd1 << (28 + ea)) - 64'd1);
        return ((pl == 2'd3) ? ub : sb) + (idx * 64'd8);
    endfunction

    function automatic logic [63:0] exp_tbl(input logic [63:0] ent, input logic [63:0] p);
        return {ent[63:3], 3'b000} + {39'd0, p[19:3], 5'd0};
    endfunction

    task automatic run_walk(input bit st, input logic [1:0] pl, input logic [4:0] a,
                            input logic [63:0] p, input logic [63:0] pv,
                            input logic [63:0] lb, input logic [63:0] ub);
        int n;
        @(negedge clk);
        op_store = st; priv = pl; user_adj = a; ptr_addr = p; ptr_val = pv;
        st_lb = lb; st_ub = ub;
        log_addr.delete();
        log_we.delete();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done reached", 64'(done), 64'd1);
        chk(busy == 1'b0, "R9 busy low at done", 64'(busy), 64'd0);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic check_store(input logic [63:0] d, input logic [63:0] t,
                               input logic [63:0] lb, input logic [63:0] ub,
                               input logic [63:0] pv);
        logic [63:0] exp_w [4];
        exp_w[0] = lb; exp_w[1] = ub; exp_w[2] = pv; exp_w[3] = 64'd0;
        chk(fault == 1'b0, "R4 no fault on valid", 64'(fault), 64'd0);
        chk(log_addr.size() == 5, "R8 store access count", 64'(log_addr.size()), 64'd5);
        if (log_addr.size() == 5) begin
            chk(log_addr[0] == d, "R2 store dir addr", log_addr[0], d);
            chk(log_we[0] == 1'b0, "R2 dir is read", 64'(log_we[0]), 64'd0);
            chk(log_addr[1] == t, "R3 table addr", log_addr[1], t);
            for (int k = 1; k < 5; k++) begin
                chk(log_addr[k] == t + 64'(8 * (k - 1)), "R5 store order", log_addr[k],
                    t + 64'(8 * (k - 1)));
                chk(log_we[k] == 1'b1, "R5 table write", 64'(log_we[k]), 64'd1);
            end
        end
        for (int k = 0; k < 4; k++) begin
            logic [63:0] v;
            v = mem.exists(t + 64'(8 * k)) ? mem[t + 64'(8 * k)] : 64'hDEAD;
            chk(v == exp_w[k], "R5 stored word", v, exp_w[k]);
        end
    endtask

    task automatic check_load(input logic [63:0] d, input logic [63:0] t,
                              input logic [63:0] lb, input logic [63:0] ub,
                              input logic [63:0] stored_pv, input bit same);
        chk(fault == 1'b0, "R4 no fault on valid load", 64'(fault), 64'd0);
        chk(log_addr.size() == 5, "R8 load access count", 64'(log_addr.size()), 64'd5);
        if (log_addr.size() == 5) begin
            chk(log_addr[0] == d, "R2 load dir addr", log_addr[0], d);
            for (int k = 1; k < 5; k++) begin
                chk(log_addr[k] == t + 64'(8 * (k - 1)), "R6 load order", log_addr[k],
                    t + 64'(8 * (k - 1)));
                chk(log_we[k] == 1'b0, "R6 table read", 64'(log_we[k]), 64'd0);
            end
        end
        if (same) begin
            chk(ld_lb == lb, "R6 ld_lb", ld_lb, lb);
            chk(ld_ub == ub, "R6 ld_ub", ld_ub, ub);
        end else begin
            chk(ld_lb == 64'd0, "R7 lb forced zero", ld_lb, 64'd0);
            chk(ld_ub == 64'd0, "R7 ub forced zero", ld_ub, 64'd0);
        end
        chk(ld_ptr == stored_pv, "R6 R7 ld_ptr", ld_ptr, stored_pv);
    endtask

    // one full store then matching load then mismatching load
    task automatic trio(input logic [1:0] pl, input logic [4:0] a, input logic [63:0] p,
                        input logic [63:0] ent, input logic [63:0] pv,
                        input logic [63:0] lb, input logic [63:0] ub, input bit miss);
        logic [63:0] d, t, other;
        mem.delete();
        d = exp_dir(p, pl, a, base_user, base_sup);
        t = exp_tbl(ent, p);
        mem[d] = ent;
        run_walk(1'b1, pl, a, p, pv, lb, ub);
        check_store(d, t, lb, ub, pv);
        after_done();
        run_walk(1'b0, pl, a, p, pv, 64'd0, 64'd0);
        check_load(d, t, lb, ub, pv, 1'b1);
        after_done();
        if (miss) begin
            other = pv ^ 64'h1;
            run_walk(1'b0, pl, a, p, other, 64'd0, 64'd0);
            check_load(d, t, lb, ub, pv, 1'b0);
            after_done();
        end
    endtask

    initial begin
        logic [63:0] p, ent, d_sup, d_usr;
        void'($urandom(32'd4711));
        base_user = 64'h0000_7000_0000_0000;
        base_sup  = 64'h0000_2000_0000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(busy == 1'b0, "R10 busy reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R10 done reset", 64'(done), 64'd0);
        chk(fault == 1'b0, "R10 fault reset", 64'(fault), 64'd0);
        chk(mem_req == 1'b0, "R10 mem_req reset", 64'(mem_req), 64'd0);

        // R1: bit 50 ignored for privilege 0, used for privilege 3 with adjust 4
        p = 64'h0004_0123_4567_89A8;
        d_sup = exp_dir(p, 2'd0, 5'd5, base_user, base_sup);
        d_usr = exp_dir(p, 2'd3, 5'd4, base_user, base_sup);
        chk(d_sup != d_usr - base_user + base_sup, "R1 bench adjust sanity", d_sup, d_usr);
        trio(2'd0, 5'd5, p, 64'h0000_5555_0000_1001, 64'hAAAA_0000_1234_5678,
             64'h1000, ~64'h1FFF, 1'b1);
        mem.delete();
        mem[d_sup] = 64'h0000_5555_0000_1001;
        run_walk(1'b0, 2'd0, 5'd5, p, 64'd0, 64'd0, 64'd0);
        if (log_addr.size() > 0)
            chk(log_addr[0] == d_sup, "R1 supervisor base", log_addr[0], d_sup);
        after_done();
        trio(2'd3, 5'd4, p, 64'h0000_6666_0000_2001, 64'h42, 64'h20, 64'h30, 1'b1);
        mem.delete();
        mem[d_usr] = 64'h1;
        run_walk(1'b0, 2'd3, 5'd4, p, 64'd0, 64'd0, 64'd0);
        if (log_addr.size() > 0)
            chk(log_addr[0] == d_usr, "R1 user base with adjust", log_addr[0], d_usr);
        after_done();

        // R1 adjust capped at 16
        p = 64'hFFFF_FFFF_FFFF_FFF8;
        trio(2'd3, 5'd31, p, 64'h0000_1111_0000_0001, 64'h9, 64'h1, 64'h2, 1'b0);

        // R3 metadata bits masked
        trio(2'd2, 5'd0, 64'h0000_0000_0012_3450, 64'h0000_3333_0000_0007,
             64'h77, 64'h5, 64'h6, 1'b0);

        // R4 invalid entry: zero and nonzero-with-bit0-clear
        for (int k = 0; k < 2; k++) begin
            mem.delete();
            p = 64'h0000_0ABC_DEF0_1238;
            mem[exp_dir(p, 2'd1, 5'd0, base_user, base_sup)] = (k == 0) ? 64'd0 : 64'h0000_4444_0000_0006;
            run_walk(k[0], 2'd1, 5'd0, p, 64'h3, 64'h4, 64'h5);
            chk(fault == 1'b1, "R4 fault raised", 64'(fault), 64'd1);
            chk(log_addr.size() == 1, "R4 no table access", 64'(log_addr.size()), 64'd1);
            after_done();
            chk(fault == 1'b0, "R4 fault one cycle", 64'(fault), 64'd0);
        end

        // random walks
        for (int it = 0; it < 40; it++) begin
            logic [1:0]  pl;
            logic [4:0]  a;
            logic [63:0] pv, lb, ub;
            pl = 2'($urandom_range(0, 3));
            a  = 5'($urandom_range(0, 31));
            base_user = {$urandom, $urandom} & ~64'h7;
            base_sup  = {$urandom, $urandom} & ~64'h7;
            p   = {$urandom, $urandom};
            ent = {$urandom, $urandom} | 64'h1;
            pv  = {$urandom, $urandom};
            lb  = {$urandom, $urandom};
            ub  = {$urandom, $urandom};
            trio(pl, a, p, ent, pv, lb, ub, it[0]);
        end

        summary();
    end

endmodule